// File: doc/BRIEF.md
# Quad-Qword Shuffle and Variable Shift Unit

This unit is a single-stage 256-bit integer datapath. A 256-bit vector is treated either as four 64-bit qwords or as eight 32-bit dwords. A 3-bit opcode picks one of three operation classes:

- **Interleave:** the low dwords of the two sources are interleaved, separately in each 128-bit lane.
- **Permute:** the qwords of the first source are rearranged under the control of an 8-bit immediate.
- **Variable shift:** each qword of the first source is shifted logically, left or right, by a count held in the matching qword of the second source.

The result is registered. It appears one clock after the input strobe, together with an output valid flag. The unit is used wherever packed 64-bit words must be rearranged, or shifted by a separate amount in each lane, within a single cycle. A typical case is stepping four occupancy masks in four directions at once.

The unit has no control state beyond the result register and the valid flag. Two register states exist:

- **Idle:** `out_valid` is low and `result` holds its last value.
- **Issue:** `out_valid` is high and `result` holds a fresh value.

A cycle with the strobe high moves the unit to Issue on the next edge. A cycle with the strobe low moves it to Idle.

Top module: `qsu_top`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `result` is all zeros from the first clock edge on.
- R2: `out_valid` equals the value that `in_valid` had one clock earlier.
- R3: For opcode 1 (interleave), dword numbering starts at 0 at bit 0. For each 128-bit lane L (L = 0, 1), result dwords 4L, 4L+1, 4L+2 and 4L+3 are A dword 4L, B dword 4L, A dword 4L+1 and B dword 4L+1. With A = A..H and B = I..P, the result is A,I,B,J,E,M,F,N.
- R4: For opcode 2 (permute), result qword i is qword `imm[2i+1:2i]` of `src_a`.
- R5: A permute may place the same source qword in several result qwords. For example, `imm` = 8'h00 copies qword 0 into all four.
- R6: For opcode 3 (shift left), each result qword is the matching `src_a` qword shifted left by the matching `src_b` qword, with zeros shifted in.
- R7: For opcode 4 (shift right), each result qword is the matching `src_a` qword shifted right logically by the matching `src_b` qword, with zeros filling from bit 63.
- R8: In either shift, a qword whose count is 64 or larger produces an all-zero result qword. This holds even when the count's low six bits are small.
- R9: Opcodes 0, 5, 6 and 7 produce an all-zero result, and `out_valid` is still asserted.
- R10: When `in_valid` is low, `result` keeps its previous value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| opcode | input | 3 | Operation select: 1 interleave, 2 permute, 3 shift left, 4 shift right |
| src_a | input | 256 | First source vector |
| src_b | input | 256 | Second source vector (interleave partner or shift counts) |
| imm | input | 8 | Permute selector, two bits per destination qword |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 256 | Registered result vector |

## Verification
Interleave is tried with distinct dword labels. This shows an in-lane pairing apart from a full-width pairing, whose result would be A,I,B,J,C,K,D,L.

Permute is tried with the identity selector, a reversal, and a broadcast. Together these expose swapped selector fields and a missing duplication path.

Shifts use four different counts per vector, including 0, 63, 64 and counts with high bits set. This separates per-element counts from a shared count, shows logical from arithmetic right shift, and shows saturation from masking the count to six bits.

Unused opcodes and strobe-low cycles that carry changed data confirm the zero result and the hold behaviour.

// File: rtl/qsu_pkg.sv
package qsu_pkg;
    localparam int VEC_W  = 256;
    localparam int QW_W   = 64;
    localparam int DW_W   = 32;
    localparam int LANE_W = 128;
    localparam int NQW    = VEC_W / QW_W;
    localparam int NLANE  = VEC_W / LANE_W;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_ILV  = 3'd1,
        OP_PERM = 3'd2,
        OP_SHL  = 3'd3,
        OP_SHR  = 3'd4
    } qsu_op_e;
endpackage

// File: rtl/qsu_interleave.sv
module qsu_interleave #(
    parameter int NLANE = 2,
    parameter int DW_W  = 32
) (
    input  logic [NLANE*2*DW_W-1:0] a_lo,
    input  logic [NLANE*2*DW_W-1:0] b_lo,
    output logic [NLANE*4*DW_W-1:0] y
);
    localparam int HALF_W = 2 * DW_W;

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        // Only the low qword of each lane feeds this lane's result.
        assign y[(4*l+0)*DW_W +: DW_W] = a_lo[l*HALF_W        +: DW_W];
        assign y[(4*l+1)*DW_W +: DW_W] = b_lo[l*HALF_W        +: DW_W];
        assign y[(4*l+2)*DW_W +: DW_W] = a_lo[l*HALF_W + DW_W +: DW_W];
        assign y[(4*l+3)*DW_W +: DW_W] = b_lo[l*HALF_W + DW_W +: DW_W];
    end
endmodule

// File: rtl/qsu_permute.sv
module qsu_permute #(
    parameter int NQW  = 4,
    parameter int QW_W = 64
) (
    input  logic [NQW*QW_W-1:0]        a,
    input  logic [NQW*$clog2(NQW)-1:0] sel,
    output logic [NQW*QW_W-1:0]        y
);
    localparam int SW = $clog2(NQW);

    for (genvar i = 0; i < NQW; i++) begin : g_dst
        logic [SW-1:0] idx;
        assign idx = sel[i*SW +: SW];
        assign y[i*QW_W +: QW_W] = a[idx*QW_W +: QW_W];
    end
endmodule

// File: rtl/qsu_varshift.sv
module qsu_varshift #(
    parameter int NQW  = 4,
    parameter int QW_W = 64,
    parameter bit LEFT = 1'b1
) (
    input  logic [NQW*QW_W-1:0] a,
    input  logic [NQW*QW_W-1:0] cnt,
    output logic [NQW*QW_W-1:0] y
);
    localparam int CW = $clog2(QW_W);

    for (genvar i = 0; i < NQW; i++) begin : g_elem
        logic [QW_W-1:0] c;
        logic            big;
        logic [QW_W-1:0] sh;
        assign c   = cnt[i*QW_W +: QW_W];
        // Any count bit at or above position CW means the count reaches the width.
        assign big = |c[QW_W-1:CW];
        if (LEFT) begin : g_l
            assign sh = a[i*QW_W +: QW_W] << c[CW-1:0];
        end else begin : g_r
            assign sh = a[i*QW_W +: QW_W] >> c[CW-1:0];
        end
        assign y[i*QW_W +: QW_W] = big ? '0 : sh;
    end
endmodule

// File: rtl/qsu_top.sv
module qsu_top
    import qsu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       opcode,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [7:0]       imm,
    output logic             out_valid,
    output logic [VEC_W-1:0] result
);
    localparam int HALF_W = LANE_W / 2;

    logic [NLANE*HALF_W-1:0] a_lo, b_lo;
    logic [VEC_W-1:0]        ilv_y, perm_y, shl_y, shr_y;
    logic [VEC_W-1:0]        next_res;
    qsu_op_e                 op;

    for (genvar l = 0; l < NLANE; l++) begin : g_lo
        assign a_lo[l*HALF_W +: HALF_W] = src_a[l*LANE_W +: HALF_W];
        assign b_lo[l*HALF_W +: HALF_W] = src_b[l*LANE_W +: HALF_W];
    end

    qsu_interleave #(.NLANE(NLANE), .DW_W(DW_W)) u_ilv (
        .a_lo(a_lo), .b_lo(b_lo), .y(ilv_y)
    );

    qsu_permute #(.NQW(NQW), .QW_W(QW_W)) u_perm (
        .a(src_a), .sel(imm), .y(perm_y)
    );

    qsu_varshift #(.NQW(NQW), .QW_W(QW_W), .LEFT(1'b1)) u_shl (
        .a(src_a), .cnt(src_b), .y(shl_y)
    );

    qsu_varshift #(.NQW(NQW), .QW_W(QW_W), .LEFT(1'b0)) u_shr (
        .a(src_a), .cnt(src_b), .y(shr_y)
    );

    assign op = qsu_op_e'(opcode);

    always_comb begin
        unique case (op)
            OP_ILV:  next_res = ilv_y;
            OP_PERM: next_res = perm_y;
            OP_SHL:  next_res = shl_y;
            OP_SHR:  next_res = shr_y;
            default: next_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (in_valid) begin
            result <= next_res;
        end
    end
endmodule

// File: rtl/qsu_checker.sv
module qsu_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [2:0]   opcode,
    input logic [255:0] src_a,
    input logic [255:0] src_b,
    input logic [7:0]   imm,
    input logic         out_valid,
    input logic [255:0] result
);
    // R2
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R10
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    // R9
    p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opcode == 3'd0 || opcode > 3'd4)) |=> (result == '0));
    // R8
    p_big_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opcode == 3'd3 || opcode == 3'd4) && src_b[63:0] >= 64'd64)
        |=> (result[63:0] == 64'd0));
    // R7
    p_shr_zero_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'd4 && src_b[127:64] != 64'd0) |=> (result[127] == 1'b0));
    // R5
    p_broadcast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'd2 && imm == 8'h00)
        |=> (result[255:192] == $past(src_a[63:0])));
    // R3
    p_ilv_lane1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == 3'd1) |=> (result[159:128] == $past(src_a[159:128])));
endmodule

bind qsu_top qsu_checker u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .src_a(src_a), .src_b(src_b), .imm(imm),
    .out_valid(out_valid), .result(result)
);

// File: tb/sim_qsu_top.sv
`timescale 1ns/1ps
module sim_qsu_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   opcode = '0;
    logic [255:0] src_a = '0;
    logic [255:0] src_b = '0;
    logic [7:0]   imm = '0;
    logic         out_valid;
    logic [255:0] result;

    int checks = 0;
    int errors = 0;
    logic [255:0] mdl_res = '0;
    logic         mdl_vld = 1'b0;

    always #2.5 clk = ~clk;

    qsu_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .src_a(src_a), .src_b(src_b), .imm(imm),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [255:0] ref_op(input logic [2:0] o, input logic [255:0] a,
                                            input logic [255:0] b, input logic [7:0] s);
        logic [255:0] r;
        logic [31:0]  da[8];
        logic [31:0]  db[8];
        logic [31:0]  dr[8];
        r = '0;
        for (int k = 0; k < 8; k++) begin
            da[k] = a[32*k +: 32];
            db[k] = b[32*k +: 32];
        end
        case (o)
            3'd1: begin
                // in-lane: per 128-bit half, pair the two lowest dwords of each source
                dr = '{da[0], db[0], da[1], db[1], da[4], db[4], da[5], db[5]};
                for (int k = 0; k < 8; k++) r[32*k +: 32] = dr[k];
            end
            3'd2: for (int i = 0; i < 4; i++) begin
                int src;
                src = (int'(s) >> (2*i)) & 3;
                r[64*i +: 64] = a[64*src +: 64];
            end
            3'd3, 3'd4: for (int i = 0; i < 4; i++) begin
                longint unsigned x, c;
                x = a[64*i +: 64];
                c = b[64*i +: 64];
                if (c >= 64) r[64*i +: 64] = '0;
                else if (o == 3'd3) r[64*i +: 64] = x << c;
                else r[64*i +: 64] = x >> c;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic compare(input string req);
        checks++;
        if (out_valid !== mdl_vld) begin
            errors++;
            $display("FAIL %s out_valid actual %0b expected %0b", req, out_valid, mdl_vld);
        end
        checks++;
        if (result !== mdl_res) begin
            errors++;
            $display("FAIL %s result actual %h expected %h", req, result, mdl_res);
        end
    endtask

    // Drive at a falling edge, let one rising edge capture, compare at the next falling edge.
    task automatic step(input logic v, input logic [2:0] o, input logic [255:0] a,
                        input logic [255:0] b, input logic [7:0] s, input string req);
        @(negedge clk);
        in_valid = v; opcode = o; src_a = a; src_b = b; imm = s;
        if (v) mdl_res = ref_op(o, a, b, s);
        mdl_vld = v;
        @(negedge clk);
        compare(req);
    endtask

    function automatic logic [255:0] labels(input int base);
        logic [255:0] r;
        for (int k = 0; k < 8; k++) r[32*k +: 32] = 32'(base + k);
        return r;
    endfunction

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [255:0] qa, qc;
        repeat (3) @(negedge clk);
        compare("R1");                               // reset state
        @(negedge clk); rst_n = 1'b1;
        compare("R1");

        // R3: distinct dword labels A..H = 0xA0.., I..P = 0xB0..
        step(1, 3'd1, labels(32'hA0), labels(32'hB0), 8'h00, "R3");
        step(1, 3'd1, {8{32'h1234_5678}} ^ labels(7), labels(32'hC000), 8'h00, "R3");

        qa = {64'h4444_0000_0000_0004, 64'h3333_0000_0000_0003,
              64'h2222_0000_0000_0002, 64'h1111_0000_0000_0001};
        step(1, 3'd2, qa, '0, 8'hE4, "R4");          // identity
        step(1, 3'd2, qa, '0, 8'h1B, "R4");          // reversal
        step(1, 3'd2, qa, '0, 8'h9C, "R4");          // mixed fields
        step(1, 3'd2, qa, '0, 8'h00, "R5");          // broadcast qword 0
        step(1, 3'd2, qa, '0, 8'hFF, "R5");          // broadcast qword 3

        qc = {64'd63, 64'd17, 64'd1, 64'd0};
        step(1, 3'd3, {4{64'h8000_0000_0000_00F1}}, qc, 8'h00, "R6");
        step(1, 3'd3, qa, {64'd4, 64'd8, 64'd12, 64'd32}, 8'h00, "R6");
        step(1, 3'd4, {4{64'hF000_0000_0000_00F1}}, qc, 8'h00, "R7");
        step(1, 3'd4, {4{64'hFFFF_FFFF_FFFF_FFFF}}, {64'd4, 64'd8, 64'd12, 64'd32}, 8'h00, "R7");

        qc = {64'h8000_0000_0000_0001, 64'd65, 64'd64, 64'd63};
        step(1, 3'd3, {4{64'hFFFF_FFFF_FFFF_FFFF}}, qc, 8'h00, "R8");
        step(1, 3'd4, {4{64'hFFFF_FFFF_FFFF_FFFF}}, qc, 8'h00, "R8");

        step(1, 3'd1, labels(5), labels(9), 8'h00, "R2");
        step(1, 3'd0, qa, qa, 8'h1B, "R9");
        step(1, 3'd2, qa, '0, 8'h1B, "R9");
        step(1, 3'd5, qa, qa, 8'h1B, "R9");
        step(1, 3'd6, qa, qa, 8'h1B, "R9");
        step(1, 3'd7, qa, qa, 8'h1B, "R9");

        step(1, 3'd2, qa, '0, 8'h1B, "R10");
        step(0, 3'd3, ~qa, qa, 8'h55, "R10");        // changed data, strobe low
        step(0, 3'd1, labels(1), labels(2), 8'h00, "R2");
        step(1, 3'd4, qa, {64'd1, 64'd2, 64'd3, 64'd4}, 8'h00, "R2");

        @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
        mdl_res = '0; mdl_vld = 1'b0;
        @(negedge clk);
        compare("R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule